// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block runs a free-running time counter that advances once per clock; at the nominal 125 MHz clock one step is 8 ns, and a 32-bit counter wraps after about 34.3 s. When a chosen edge appears on the selected trigger source, the block copies the counter into a capture register. The source is either an asynchronous external request pin or a synchronous internal pulse. The external pin first passes through a two-flop synchronizer.

Software reaches the block through a plain register port. Writes take effect on the next clock edge, and reads return data combinationally for the address presented. Software picks the trigger edge and the source, then reads a status word and after it the captured time as low and high 16-bit halves. Writing zero to the valid bit re-arms the unit. The capture stays held until software does this. An event that arrives while a capture is pending raises an error flag, and an optional overwrite mode replaces the held time. A saturating counter records how many captures were stored. Every write to the status word clears this counter.

Top module: `event_stamp_top`

## Requirements
- R1: The time counter (`timeNow`) is 0 in reset and advances by exactly 1 on every clock edge after reset, modulo 2^TIME_W.
- R2: Register addresses: 0 = config (bit0 falling-edge select, bit1 overwrite enable, bit2 counter run), 1 = status, 2 = captured time bits 15:0, 3 = captured time bits 31:16. Reads are combinational, and config reads back as written in bits 2:0 with zeros above.
- R3: With config bit0 = 0 only rising edges of the selected source trigger a capture. With bit0 = 1 only falling edges do, and edges of the opposite direction are ignored.
- R4: Status bit2 selects the source: 1 = internal pulse, 0 = external request. Edges on the unselected source have no effect.
- R5: An external edge stores (T + 2), where T is the `timeNow` value in the cycle the pin changes. An internal edge stores T itself. Either one sets valid (status bit0).
- R6: With overwrite disabled, an event that arrives while valid is set leaves the captured time unchanged.
- R7: An event while valid is set sets error (status bit1). With overwrite enabled, that event also replaces the captured time. A status write with bit1 = 0 clears error, and with bit1 = 1 leaves it.
- R8: A status write with bit0 = 0 clears valid and re-arms capture. A status write with bit0 = 1 leaves valid unchanged.
- R9: The capture counter (status bits 15:8) counts each stored capture only while config bit2 = 1. It saturates at 255, and any status write clears it to 0.
- R10: After reset all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| extReq | input | 1 | Asynchronous external event request |
| intPulse | input | 1 | Synchronous internal trigger pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| timeNow | output | 32 | Current time counter value |

## Verification
The bench goes after the pending-event window, which is where the error and overwrite rules meet. A design that overwrote without permission would show a newer time than the first event. One that forgot to flag the miss would leave error clear. The bench measures the external-path latency exactly, so a missing or extra synchronizer stage moves the stored time by one count. It also fires edges of the wrong direction and on the unselected source, which would wrongly set valid in a design with a broken edge or source select. Finally it drives more than 255 overwrite captures and then stops counting, so a counter that wraps or ignores the run bit reads back the wrong value.

// File: rtl/event_stamp_pkg.sv
package event_stamp_pkg;
  localparam int REG_W      = 16;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_CFG   = 2'd0,
    ADDR_STS   = 2'd1,
    ADDR_CAPLO = 2'd2,
    ADDR_CAPHI = 2'd3
  } regAddr_e;

  // config word bits
  localparam int CFG_FALL_BIT = 0;
  localparam int CFG_OVW_BIT  = 1;
  localparam int CFG_RUN_BIT  = 2;
  // status word bits
  localparam int STS_VALID_BIT = 0;
  localparam int STS_ERR_BIT   = 1;
  localparam int STS_SRC_BIT   = 2;
  localparam int STS_CNT_LSB   = 8;
  localparam int STS_CNT_W     = 8;

  typedef struct packed {
    logic loadCap;
    logic cntInc;
    logic cntClr;
  } capStrobe_t;
endpackage

// File: rtl/event_stamp_ctrl.sv
module event_stamp_ctrl
  import event_stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  extReq,
  input  logic                  intPulse,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output capStrobe_t            strobe,
  output logic                  cfgFall,
  output logic                  cfgOvw,
  output logic                  cfgRun,
  output logic                  srcInt,
  output logic                  validFlag,
  output logic                  errFlag,
  output logic                  evtFire
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic extSync, extPrev, intPrev;
  logic extEdge, intEdge;
  logic cfgWr, stsWr, clrValid, clrErr, pendingEff;
  logic unusedBits;

  assign unusedBits = ^regWrData[REG_W-1:3];

  // two-flop (parameterised) synchronizer for the asynchronous request
  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], extReq};
  end
  assign extSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      intPrev <= 1'b0;
    end else begin
      extPrev <= extSync;
      intPrev <= intPulse;
    end
  end

  assign extEdge = cfgFall ? (extPrev & ~extSync) : (extSync & ~extPrev);
  assign intEdge = cfgFall ? (intPrev & ~intPulse) : (intPulse & ~intPrev);
  assign evtFire = srcInt ? intEdge : extEdge;

  assign cfgWr    = regWrEn && (regAddr == ADDR_CFG);
  assign stsWr    = regWrEn && (regAddr == ADDR_STS);
  assign clrValid = stsWr && !regWrData[STS_VALID_BIT];
  assign clrErr   = stsWr && !regWrData[STS_ERR_BIT];
  // a same-cycle re-arm write frees the slot for a simultaneous event
  assign pendingEff = validFlag && !clrValid;

  always_comb begin
    strobe.loadCap = evtFire && (!pendingEff || cfgOvw);
    strobe.cntInc  = strobe.loadCap && cfgRun && !stsWr;
    strobe.cntClr  = stsWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgFall <= 1'b0;
      cfgOvw  <= 1'b0;
      cfgRun  <= 1'b0;
    end else if (cfgWr) begin
      cfgFall <= regWrData[CFG_FALL_BIT];
      cfgOvw  <= regWrData[CFG_OVW_BIT];
      cfgRun  <= regWrData[CFG_RUN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcInt    <= 1'b0;
      validFlag <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (stsWr) srcInt <= regWrData[STS_SRC_BIT];
      if (evtFire)       validFlag <= 1'b1;
      else if (clrValid) validFlag <= 1'b0;
      if (evtFire && pendingEff) errFlag <= 1'b1;
      else if (clrErr)           errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/event_stamp_dp.sv
module event_stamp_dp
  import event_stamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  output logic [TIME_W-1:0] timeCnt,
  output logic [TIME_W-1:0] capTime,
  output logic [CNT_W-1:0]  capCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) timeCnt <= '0;
    else       timeCnt <= timeCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               capTime <= '0;
    else if (strobe.loadCap) capTime <= timeCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  capCount <= '0;
    else if (strobe.cntClr)                     capCount <= '0;
    else if (strobe.cntInc && capCount != CNT_MAX) capCount <= capCount + 1'b1;
  end
endmodule

// File: rtl/event_stamp_top.sv
module event_stamp_top
  import event_stamp_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  extReq,
  input  logic                  intPulse,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  output logic [TIME_W-1:0]     timeNow
);
  localparam int WIDE_W = 2 * REG_W;

  capStrobe_t        strobe;
  logic              cfgFall, cfgOvw, cfgRun, srcInt;
  logic              validFlag, errFlag, evtFire;
  logic [TIME_W-1:0] capTime;
  logic [CNT_W-1:0]  capCount;
  logic [WIDE_W-1:0] capWide;

  event_stamp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .extReq(extReq), .intPulse(intPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe), .cfgFall(cfgFall), .cfgOvw(cfgOvw), .cfgRun(cfgRun),
    .srcInt(srcInt), .validFlag(validFlag), .errFlag(errFlag), .evtFire(evtFire)
  );

  event_stamp_dp #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .timeCnt(timeNow), .capTime(capTime), .capCount(capCount)
  );

  assign capWide = WIDE_W'(capTime);

  always_comb begin
    regRdData = '0;
    case (regAddr_e'(regAddr))
      ADDR_CFG: begin
        regRdData[CFG_FALL_BIT] = cfgFall;
        regRdData[CFG_OVW_BIT]  = cfgOvw;
        regRdData[CFG_RUN_BIT]  = cfgRun;
      end
      ADDR_STS: begin
        regRdData[STS_VALID_BIT] = validFlag;
        regRdData[STS_ERR_BIT]   = errFlag;
        regRdData[STS_SRC_BIT]   = srcInt;
        regRdData[STS_CNT_LSB +: STS_CNT_W] = STS_CNT_W'(capCount);
      end
      ADDR_CAPLO: regRdData = capWide[REG_W-1:0];
      default:    regRdData = capWide[WIDE_W-1:REG_W];
    endcase
  end
endmodule

// File: rtl/event_stamp_chk.sv
module event_stamp_chk
  import event_stamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  wrValidBit,
  input logic [TIME_W-1:0]     timeNow,
  input logic [TIME_W-1:0]     capTime,
  input logic [CNT_W-1:0]      capCount,
  input logic                  validFlag,
  input logic                  errFlag,
  input logic                  evtFire,
  input logic                  cfgOvw
);
  logic stsWr;
  assign stsWr = regWrEn && (regAddr == ADDR_STS);

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> timeNow == TIME_W'($past(timeNow) + 1'b1)); // R1

  AST_EVT_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    evtFire |=> validFlag); // R5

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (validFlag && !cfgOvw && !stsWr) |=> $stable(capTime)); // R6

  AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (evtFire && validFlag && !(stsWr && !wrValidBit)) |=> errFlag); // R7

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stsWr |=> capCount == '0); // R9

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (capCount == '1) |=> (capCount == '1 || capCount == '0)); // R9
endmodule

bind event_stamp_top event_stamp_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrValidBit(regWrData[0]), .timeNow(timeNow), .capTime(capTime),
  .capCount(capCount), .validFlag(validFlag), .errFlag(errFlag),
  .evtFire(evtFire), .cfgOvw(cfgOvw)
);

// File: tb/event_stamp_top_tb.sv
module event_stamp_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extReq = 1'b0;
  logic        intPulse = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic [31:0] timeNow;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  logic        mValid = 0, mErr = 0, mSrc = 0, mFall = 0, mOvw = 0, mRun = 0;
  logic [31:0] mCap = 0;
  logic [7:0]  mCnt = 0;

  event_stamp_top u_dut (
    .clk(clk), .rstN(rstN), .extReq(extReq), .intPulse(intPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .timeNow(timeNow)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] satInc(input logic [7:0] c);
    return (c == 8'hFF) ? c : c + 8'd1;
  endfunction

  function automatic logic [31:0] extExpected(input logic [31:0] t);
    return t + 32'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic writeStatus(input logic src, input logic keepErr, input logic keepValid);
    regWrite(2'd1, {13'd0, src, keepErr, keepValid});
    if (!keepValid) mValid = 0;
    if (!keepErr) mErr = 0;
    mSrc = src;
    mCnt = 0;
  endtask

  task automatic setConfig(input logic fall, input logic ovw, input logic run);
    regWrite(2'd0, {13'd0, run, ovw, fall});
    mFall = fall; mOvw = ovw; mRun = run;
    @(negedge clk);
    extReq = fall;      // move to idle level: edge of the ignored direction
    intPulse = fall;
    repeat (5) @(negedge clk);
  endtask

  task automatic modelEvent(input logic [31:0] t);
    if (!mValid) begin
      mCap = t; mValid = 1;
      if (mRun) mCnt = satInc(mCnt);
    end else begin
      mErr = 1;
      if (mOvw) begin
        mCap = t;
        if (mRun) mCnt = satInc(mCnt);
      end
    end
  endtask

  task automatic fireInt();
    logic [31:0] t;
    @(negedge clk);
    t = timeNow;
    intPulse = ~mFall;
    @(negedge clk);
    intPulse = mFall;
    if (mSrc) modelEvent(t);
    @(negedge clk);
  endtask

  task automatic fireExt();
    logic [31:0] t;
    @(negedge clk);
    t = timeNow;
    extReq = ~mFall;
    repeat (4) @(negedge clk);
    extReq = mFall;
    if (!mSrc) modelEvent(extExpected(t));
    repeat (4) @(negedge clk);
  endtask

  task automatic checkState(input string capTag);
    logic [15:0] s, lo, hi;
    regRead(2'd1, s);
    regRead(2'd2, lo);
    regRead(2'd3, hi);
    chk("R8 valid", 32'(s[0]), 32'(mValid));
    chk("R7 error", 32'(s[1]), 32'(mErr));
    chk("R4 source", 32'(s[2]), 32'(mSrc));
    chk("R9 count", 32'(s[15:8]), 32'(mCnt));
    chk(capTag, {hi, lo}, mCap);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] t0;
    int unusedSeed;
    unusedSeed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 time in reset", timeNow, 32'd0);
    regRead(2'd0, v); chk("R10 config", 32'(v), 32'd0);
    regRead(2'd1, v); chk("R10 status", 32'(v), 32'd0);
    regRead(2'd3, v); chk("R10 capHi", 32'(v), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: counter steps once per clock
    @(negedge clk);
    t0 = timeNow;
    repeat (10) @(negedge clk);
    chk("R1 time step", timeNow, t0 + 32'd10);

    // R2: config readback
    regWrite(2'd0, 16'hFFF6);
    regRead(2'd0, v);
    chk("R2 config readback", 32'(v), 32'h6);

    setConfig(1'b0, 1'b0, 1'b1);
    writeStatus(1'b0, 1'b0, 1'b0);

    fireExt();
    checkState("R5 external capture");
    fireInt();               // unselected source
    checkState("R4 unselected ignored");
    fireExt();               // pending, overwrite off
    checkState("R6 held capture");
    writeStatus(1'b0, 1'b1, 1'b0);
    checkState("R8 rearm keeps error");

    writeStatus(1'b1, 1'b0, 1'b0);
    fireInt();
    checkState("R5 internal capture");
    fireExt();               // unselected source
    checkState("R4 unselected ext ignored");

    setConfig(1'b0, 1'b1, 1'b1);
    fireInt();               // pending, overwrite on
    checkState("R7 overwrite capture");

    writeStatus(1'b1, 1'b0, 1'b1); // R8: valid kept by writing 1
    checkState("R8 write one keeps valid");

    writeStatus(1'b1, 1'b0, 1'b0);
    setConfig(1'b1, 1'b1, 1'b1); // rising transition to idle is ignored
    checkState("R3 opposite edge ignored");
    fireInt();
    checkState("R3 falling capture");
    writeStatus(1'b0, 1'b0, 1'b0);
    fireExt();
    checkState("R3 falling ext capture");

    // R9 saturation
    setConfig(1'b0, 1'b1, 1'b1);
    writeStatus(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 260; i++) fireInt();
    checkState("R9 saturation capture");

    // R9 run bit off
    setConfig(1'b0, 1'b1, 1'b0);
    writeStatus(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) fireInt();
    checkState("R9 run off capture");

    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      case ($urandom_range(0, 5))
        0, 1: fireInt();
        2, 3: fireExt();
        4: writeStatus(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)));
        default: setConfig(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                           1'($urandom_range(0, 1)));
      endcase
      checkState("R5 R6 random capture");
    end

    finishRun();
  end
endmodule